// File: doc/BRIEF.md
# Infrared run-length capture receiver

This block watches the one-bit output of an infrared demodulator and records the received waveform as a stream of run-length bytes. It samples the line on a slow sample tick taken from the module clock, can invert it, and removes short glitches. Each run of constant level becomes one or more bytes in a receive FIFO. Each byte carries the run's level and its length in sample ticks. Software or a downstream decoder pops the bytes and rebuilds the pulse/space timing. Protocol decoding is done outside the block.

A burst only counts as the start of a frame once the line has been active for a programmable number of ticks. A frame closes once the line has stayed in space for a programmable idle time. A status word reports how many entries are waiting, whether a frame has ended and whether an entry was lost to a full FIFO. An interrupt output combines the enabled flags.

Top module: `irrx_capture`

## Requirements
- R1: After reset, `status` is 0x0000, `irq` is 0 and `rd_data` is 0x00.
- R2: One sample tick occurs every `cfg_div`+1 clock cycles. All durations and thresholds count sample ticks.
- R3: When `cfg_invert` is 1, the sampled line is inverted before any other processing, so a low line is treated as a pulse.
- R4: The filtered level follows the sampled level only after `cfg_filt`+1 consecutive ticks that disagree with it. A shorter disagreement leaves no trace in the entries.
- R5: While no frame is open, nothing is pushed. A frame opens on the tick where the filtered pulse level has lasted `cfg_active` ticks. A shorter burst pushes nothing.
- R6: Each entry is one byte. Bit 7 is the level (1 = pulse) and bits 6:0 are the run length in ticks, never 0. An entry is pushed when the filtered level changes during a frame.
- R7: A run reaching 127 ticks pushes an entry of length 127, and counting continues in a new entry with the same level. The entry lengths add up to the full run.
- R8: During a frame, once a space has lasted `cfg_idle` ticks, the next space tick pushes the space entry, closes the frame and sets the frame-end flag at status bit 1.
- R9: An entry pushed while 64 entries are held is dropped and sets the overflow flag at status bit 0.
- R10: Status bits 14:8 give the number of entries held. Bit 4 is 1 whenever at least 32 entries are held. Bits 15, 7:5 and 3:2 read 0.
- R11: Bits 0 and 1 stay set until a cycle with `clr_we`=1 and a 1 in the matching bit of `clr_bits`. Writing 0xEF clears both. A set in the same cycle wins over the clear.
- R12: `irq` is 1 exactly when some bit of `status[7:0]` and the same bit of `cfg_int_en` are both 1.
- R13: `rd_data` shows the oldest held entry, or 0x00 when the FIFO is empty. A cycle with `pop`=1 removes that entry. A pop on an empty FIFO has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ir_raw | input | 1 | Demodulated infrared line |
| cfg_div | input | 8 | Sample divider, tick every value+1 clocks |
| cfg_invert | input | 1 | Invert the sampled line |
| cfg_filt | input | 6 | Glitch filter threshold |
| cfg_active | input | 7 | Pulse ticks needed to open a frame |
| cfg_idle | input | 8 | Space ticks that close a frame |
| cfg_int_en | input | 8 | Interrupt enable per status flag bit |
| pop | input | 1 | Remove the oldest entry |
| clr_we | input | 1 | Flag clear strobe |
| clr_bits | input | 8 | Write-one-to-clear mask for the flags |
| rd_data | output | 8 | Oldest entry, 0 when empty |
| status | output | 16 | Entry count and flags |
| irq | output | 1 | Interrupt |

## Verification
The assertions check the following on every cycle: the count stays within the FIFO depth, the reserved bits and the half-full bit agree with the count, and no entry has length zero. They also check that a full FIFO hit by a push raises the overflow flag, that the flag holds until it is cleared, that a frame-end flag follows a pushed space entry, that a pop drains exactly one entry, and that a rising frame-end flag with its enable set drives the interrupt. Some behaviours can only be shown by the bench scenarios, with the exact byte sequences compared against a behavioural model every clock: the split of long runs at 127, the glitch filter delay, the inverted line, short bursts that must leave nothing, and the idle-time closure.

// File: rtl/irrx_pkg.sv
package irrx_pkg;
    localparam int DUR_W = 7;
    localparam logic [DUR_W-1:0] DUR_MAX = '1;

    typedef enum logic {
        RX_WAIT  = 1'b0,
        RX_FRAME = 1'b1
    } rx_state_e;

    typedef struct packed {
        logic             level;
        logic [DUR_W-1:0] dur;
    } entry_t;

    localparam int ENTRY_W = $bits(entry_t);

    // status flag positions
    localparam int ST_OVF  = 0;
    localparam int ST_END  = 1;
    localparam int ST_HALF = 4;
endpackage

// File: rtl/irrx_ticker.sv
module irrx_ticker #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_i,
    output logic             tick_o
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
    } tk_t;

    tk_t tk_d, tk_q;

    always_comb begin
        tk_d   = tk_q;
        tick_o = (tk_q.cnt == div_i);
        if (tick_o) tk_d.cnt = '0;
        else        tk_d.cnt = tk_q.cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tk_q <= '0;
        else        tk_q <= tk_d;
    end
endmodule

// File: rtl/irrx_filter.sv
module irrx_filter #(
    parameter int FILT_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              raw_i,
    input  logic              invert_i,
    input  logic [FILT_W-1:0] thr_i,
    output logic              lvl_o
);
    typedef struct packed {
        logic              level;
        logic [FILT_W-1:0] gcnt;
    } fl_t;

    fl_t fl_d, fl_q;
    logic smp;

    always_comb begin
        fl_d = fl_q;
        smp  = raw_i ^ invert_i;
        if (tick_i) begin
            if (smp == fl_q.level) begin
                fl_d.gcnt = '0;
            end else if (fl_q.gcnt >= thr_i) begin
                fl_d.level = smp;
                fl_d.gcnt  = '0;
            end else begin
                fl_d.gcnt = fl_q.gcnt + 1'b1;
            end
        end
        lvl_o = fl_d.level;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) fl_q <= '0;
        else        fl_q <= fl_d;
    end
endmodule

// File: rtl/irrx_runlen.sv
module irrx_runlen
    import irrx_pkg::*;
#(
    parameter int IDLE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              lvl_i,
    input  logic [DUR_W-1:0]  act_thr_i,
    input  logic [IDLE_W-1:0] idle_thr_i,
    output logic              push_o,
    output entry_t            entry_o,
    output logic              end_o
);
    typedef struct packed {
        rx_state_e         state;
        logic              level;
        logic [DUR_W-1:0]  run;
        logic [IDLE_W-1:0] idl;
    } rl_t;

    rl_t rl_d, rl_q;

    always_comb begin
        rl_d    = rl_q;
        push_o  = 1'b0;
        entry_o = '0;
        end_o   = 1'b0;
        if (tick_i) begin
            unique case (rl_q.state)
                RX_WAIT: begin
                    if (lvl_i) begin
                        if (({1'b0, rl_q.run} + 1'b1) >= {1'b0, act_thr_i}) begin
                            rl_d.state = RX_FRAME;
                            rl_d.level = 1'b1;
                            rl_d.idl   = '0;
                        end
                        rl_d.run = rl_q.run + 1'b1;
                    end else begin
                        rl_d.run = '0;
                    end
                end
                RX_FRAME: begin
                    if (lvl_i != rl_q.level) begin
                        push_o     = 1'b1;
                        entry_o    = '{level: rl_q.level, dur: rl_q.run};
                        rl_d.level = lvl_i;
                        rl_d.run   = DUR_W'(1);
                        rl_d.idl   = lvl_i ? '0 : IDLE_W'(1);
                    end else if (!rl_q.level && (rl_q.idl >= idle_thr_i)) begin
                        push_o     = 1'b1;
                        entry_o    = '{level: 1'b0, dur: rl_q.run};
                        end_o      = 1'b1;
                        rl_d.state = RX_WAIT;
                        rl_d.run   = '0;
                        rl_d.idl   = '0;
                    end else begin
                        if (rl_q.run == DUR_MAX) begin
                            push_o   = 1'b1;
                            entry_o  = '{level: rl_q.level, dur: DUR_MAX};
                            rl_d.run = DUR_W'(1);
                        end else begin
                            rl_d.run = rl_q.run + 1'b1;
                        end
                        if (!rl_q.level && (rl_q.idl != '1))
                            rl_d.idl = rl_q.idl + 1'b1;
                    end
                end
                default: rl_d = rl_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rl_q <= '{state: RX_WAIT, level: 1'b0, run: '0, idl: '0};
        else        rl_q <= rl_d;
    end
endmodule

// File: rtl/irrx_fifo.sv
module irrx_fifo #(
    parameter int DEPTH = 64,
    parameter int WIDTH = 8,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = AW + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_i,
    input  logic [WIDTH-1:0] data_i,
    input  logic             pop_i,
    output logic [WIDTH-1:0] head_o,
    output logic [CW-1:0]    count_o,
    output logic             drop_o
);
    typedef struct packed {
        logic [AW-1:0] wptr;
        logic [AW-1:0] rptr;
        logic [CW-1:0] count;
    } ff_t;

    ff_t ff_d, ff_q;
    logic [WIDTH-1:0] mem_q [DEPTH];
    logic push_ok, pop_ok;

    always_comb begin
        ff_d    = ff_q;
        pop_ok  = pop_i && (ff_q.count != '0);
        push_ok = push_i && (ff_q.count != CW'(DEPTH));
        drop_o  = push_i && (ff_q.count == CW'(DEPTH));
        if (push_ok) ff_d.wptr = ff_q.wptr + 1'b1;
        if (pop_ok)  ff_d.rptr = ff_q.rptr + 1'b1;
        ff_d.count = ff_q.count + CW'(push_ok) - CW'(pop_ok);
        head_o  = (ff_q.count == '0) ? '0 : mem_q[ff_q.rptr];
        count_o = ff_q.count;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ff_q <= '0;
        else        ff_q <= ff_d;
    end

    always_ff @(posedge clk) begin
        if (push_ok) mem_q[ff_q.wptr] <= data_i;
    end
endmodule

// File: rtl/irrx_capture.sv
module irrx_capture
    import irrx_pkg::*;
#(
    parameter int DIV_W  = 8,
    parameter int FILT_W = 6,
    parameter int IDLE_W = 8,
    parameter int DEPTH  = 64,
    localparam int CW     = $clog2(DEPTH) + 1,
    localparam int CNT_W  = 7,
    localparam int HALF   = DEPTH / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ir_raw,
    input  logic [DIV_W-1:0]  cfg_div,
    input  logic              cfg_invert,
    input  logic [FILT_W-1:0] cfg_filt,
    input  logic [DUR_W-1:0]  cfg_active,
    input  logic [IDLE_W-1:0] cfg_idle,
    input  logic [7:0]        cfg_int_en,
    input  logic              pop,
    input  logic              clr_we,
    input  logic [7:0]        clr_bits,
    output logic [7:0]        rd_data,
    output logic [15:0]       status,
    output logic              irq
);
    typedef struct packed {
        logic ovf;
        logic fend;
    } fl_t;

    fl_t    st_d, st_q;
    logic   tick, lvl, rl_push, rl_end, drop;
    entry_t rl_entry;
    logic [CW-1:0] fifo_cnt;
    logic [7:0]    flags;

    irrx_ticker #(.DIV_W(DIV_W)) u_tick (
        .clk(clk), .rst_n(rst_n), .div_i(cfg_div), .tick_o(tick)
    );

    irrx_filter #(.FILT_W(FILT_W)) u_filt (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .raw_i(ir_raw),
        .invert_i(cfg_invert), .thr_i(cfg_filt), .lvl_o(lvl)
    );

    irrx_runlen #(.IDLE_W(IDLE_W)) u_run (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .lvl_i(lvl),
        .act_thr_i(cfg_active), .idle_thr_i(cfg_idle),
        .push_o(rl_push), .entry_o(rl_entry), .end_o(rl_end)
    );

    irrx_fifo #(.DEPTH(DEPTH), .WIDTH(ENTRY_W)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push_i(rl_push), .data_i(rl_entry),
        .pop_i(pop), .head_o(rd_data), .count_o(fifo_cnt), .drop_o(drop)
    );

    always_comb begin
        st_d = st_q;
        if (clr_we && clr_bits[ST_OVF]) st_d.ovf  = 1'b0;
        if (clr_we && clr_bits[ST_END]) st_d.fend = 1'b0;
        if (drop)   st_d.ovf  = 1'b1;
        if (rl_end) st_d.fend = 1'b1;

        flags          = '0;
        flags[ST_OVF]  = st_q.ovf;
        flags[ST_END]  = st_q.fend;
        flags[ST_HALF] = (fifo_cnt >= CW'(HALF));
        status = {1'b0, CNT_W'(fifo_cnt), flags};
        irq    = |(flags & cfg_int_en);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/irrx_capture_chk.sv
module irrx_capture_chk #(
    parameter int DEPTH = 64
) (
    input logic        clk,
    input logic        rst_n,
    input logic        pop,
    input logic        clr_ovf,
    input logic [15:0] status,
    input logic [7:0]  int_en,
    input logic        irq,
    input logic        push,
    input logic [7:0]  push_entry
);
    assert_count_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
        status[14:8] <= 7'(DEPTH));

    assert_reserved_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (status[15] == 1'b0) && (status[7:5] == 3'b0) && (status[3:2] == 2'b0));

    assert_half_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (status[14:8] < 7'(DEPTH / 2)) |-> !status[4]);

    assert_entry_nonzero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (push_entry[6:0] != 7'd0));

    assert_ovf_on_full_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (push && (status[14:8] == 7'(DEPTH))) |=> status[0]);

    assert_ovf_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (status[0] && !clr_ovf) |=> status[0]);

    assert_end_after_space_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[1]) |-> $past(push && !push_entry[7]));

    assert_pop_drain_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && (status[14:8] != 7'd0) && !push) |=> (status[14:8] == $past(status[14:8]) - 7'd1));

    assert_irq_masked_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (int_en == 8'd0) |-> !irq);

    assert_irq_end_R12: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(status[1]) && int_en[1]) |-> irq);
endmodule

bind irrx_capture irrx_capture_chk #(.DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .pop(pop), .clr_ovf(clr_we & clr_bits[0]),
    .status(status), .int_en(cfg_int_en), .irq(irq),
    .push(rl_push), .push_entry(rl_entry)
);

// File: tb/irrx_capture_test.sv
module irrx_capture_test;
    localparam int DEPTH = 64;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ir_raw = 1'b0;
    logic [7:0] cfg_div = 8'd1;
    logic       cfg_invert = 1'b0;
    logic [5:0] cfg_filt = 6'd0;
    logic [6:0] cfg_active = 7'd3;
    logic [7:0] cfg_idle = 8'd10;
    logic [7:0] cfg_int_en = 8'd0;
    logic       pop = 1'b0;
    logic       clr_we = 1'b0;
    logic [7:0] clr_bits = 8'd0;
    logic [7:0] rd_data;
    logic [15:0] status;
    logic       irq;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    bit done = 0;

    irrx_capture uut (
        .clk(clk), .rst_n(rst_n), .ir_raw(ir_raw), .cfg_div(cfg_div),
        .cfg_invert(cfg_invert), .cfg_filt(cfg_filt), .cfg_active(cfg_active),
        .cfg_idle(cfg_idle), .cfg_int_en(cfg_int_en), .pop(pop),
        .clr_we(clr_we), .clr_bits(clr_bits), .rd_data(rd_data),
        .status(status), .irq(irq)
    );

    always #10 clk = ~clk;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // behavioural reference model
    int m_pc, m_lv, m_g, m_frame, m_level, m_run, m_idl, m_ovf, m_end;
    int m_push, m_ent, m_fin, m_sz, m_s;
    byte unsigned q[$];

    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            m_pc = 0; m_lv = 0; m_g = 0; m_frame = 0; m_level = 0;
            m_run = 0; m_idl = 0; m_ovf = 0; m_end = 0;
            q.delete();
        end else begin
            m_push = 0; m_fin = 0; m_ent = 0;
            if (m_pc == int'(cfg_div)) begin
                m_pc = 0;
                m_s = int'(ir_raw ^ cfg_invert);
                if (m_s == m_lv) m_g = 0;
                else if (m_g >= int'(cfg_filt)) begin m_lv = m_s; m_g = 0; end
                else m_g++;
                if (!m_frame) begin
                    if (m_lv == 1) begin
                        m_run++;
                        if (m_run >= int'(cfg_active)) begin
                            m_frame = 1; m_level = 1; m_idl = 0;
                        end
                    end else m_run = 0;
                end else if (m_lv != m_level) begin
                    m_push = 1; m_ent = m_level * 128 + m_run;
                    m_level = m_lv; m_run = 1; m_idl = (m_lv == 1) ? 0 : 1;
                end else if (m_level == 0 && m_idl >= int'(cfg_idle)) begin
                    m_push = 1; m_ent = m_run; m_fin = 1;
                    m_frame = 0; m_run = 0; m_idl = 0;
                end else begin
                    if (m_run == 127) begin
                        m_push = 1; m_ent = m_level * 128 + 127; m_run = 1;
                    end else m_run++;
                    if (m_level == 0 && m_idl < 255) m_idl++;
                end
            end else begin
                m_pc = (m_pc + 1) % 256;
            end
            m_sz = q.size();
            if (pop && m_sz > 0) void'(q.pop_front());
            if (clr_we && clr_bits[0]) m_ovf = 0;
            if (clr_we && clr_bits[1]) m_end = 0;
            if (m_push) begin
                if (m_sz == DEPTH) m_ovf = 1;
                else q.push_back(byte'(m_ent));
            end
            if (m_fin) m_end = 1;
        end
    end

    // per-cycle comparison, sampled after the edge has settled
    always @(posedge clk) begin
        #1;
        if (rst_n && !done) begin
            automatic int sz = q.size();
            automatic int flg = m_ovf | (m_end << 1) | ((sz >= 32) << 4);
            automatic int exp_st = (sz << 8) | flg;
            check(status[14:8] == sz, "R10 count field", status[14:8], sz);
            check(status[4] == (sz >= 32), "R10 half flag", status[4], (sz >= 32));
            check(status[0] == m_ovf[0], "R9 overflow flag", status[0], m_ovf);
            check(status[1] == m_end[0], "R8 frame-end flag", status[1], m_end);
            check(status == exp_st[15:0], "R6 status word", status, exp_st);
            check(irq == ((flg & int'(cfg_int_en)) != 0), "R12 irq", irq, ((flg & int'(cfg_int_en)) != 0));
            if (sz > 0) check(rd_data == q[0], "R13 head entry", rd_data, q[0]);
            else        check(rd_data == 8'h00, "R13 empty read", rd_data, 0);
        end
    end

    task automatic hold(input bit lvl, input int n);
        ir_raw = lvl;
        repeat (n * (int'(cfg_div) + 1)) @(negedge clk);
    endtask

    task automatic expect_pop(input int exp, input string tag);
        check(rd_data == exp[7:0], tag, rd_data, exp);
        pop = 1'b1;
        @(negedge clk);
        pop = 1'b0;
    endtask

    task automatic clear(input logic [7:0] m);
        clr_we = 1'b1; clr_bits = m;
        @(negedge clk);
        clr_we = 1'b0; clr_bits = 8'd0;
    endtask

    task automatic drain();
        while (status[14:8] != 7'd0) begin
            pop = 1'b1;
            @(negedge clk);
        end
        pop = 1'b0;
        clear(8'hEF);
        @(negedge clk);
    endtask

    initial begin
        while (cycles < 150000 && !done) @(negedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        // R1 reset state
        check(status == 16'h0000, "R1 reset status", status, 0);
        check(irq == 1'b0, "R1 reset irq", irq, 0);
        check(rd_data == 8'h00, "R1 reset data", rd_data, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R6 R8: basic frame, active 3, idle 10
        hold(1, 5); hold(0, 4); hold(1, 2); hold(0, 20);
        check(status[14:8] == 7'd4, "R10 four entries", status[14:8], 4);
        check(status[1] == 1'b1, "R8 frame end set", status[1], 1);
        cfg_int_en = 8'h02;
        @(negedge clk);
        check(irq == 1'b1, "R12 irq on frame end", irq, 1);
        cfg_int_en = 8'h00;
        @(negedge clk);
        check(irq == 1'b0, "R12 irq masked", irq, 0);
        expect_pop(8'h85, "R6 pulse entry");
        expect_pop(8'h04, "R6 space entry");
        expect_pop(8'h82, "R6 short pulse");
        expect_pop(8'h0A, "R8 closing space");
        clear(8'h02);
        check(status == 16'h0000, "R11 clear frame end", status, 0);

        // R5: burst too short to open a frame
        hold(1, 2); hold(0, 5);
        check(status == 16'h0000, "R5 short burst ignored", status, 0);

        // R7: long pulse split at 127
        hold(1, 300); hold(0, 20);
        expect_pop(8'hFF, "R7 first chunk");
        expect_pop(8'hFF, "R7 second chunk");
        expect_pop(8'hAE, "R7 remainder");
        expect_pop(8'h0A, "R8 space after long run");
        drain();

        // R2: slower sample tick
        cfg_div = 8'd3;
        hold(1, 8); hold(0, 20);
        expect_pop(8'h88, "R2 divided pulse length");
        expect_pop(8'h0A, "R2 divided space length");
        drain();
        cfg_div = 8'd1;
        repeat (600) @(negedge clk);

        // R3: inverted line
        cfg_invert = 1'b1; ir_raw = 1'b1;
        repeat (10) @(negedge clk);
        hold(0, 5); hold(1, 4); hold(0, 2); hold(1, 20);
        expect_pop(8'h85, "R3 inverted pulse");
        expect_pop(8'h04, "R3 inverted space");
        expect_pop(8'h82, "R3 inverted short pulse");
        expect_pop(8'h0A, "R3 inverted close");
        ir_raw = 1'b0; cfg_invert = 1'b0;
        drain();

        // R4: glitch filter of 2
        cfg_filt = 6'd2;
        hold(1, 5); hold(0, 2); hold(1, 5); hold(0, 20);
        expect_pop(8'h8C, "R4 glitch absorbed");
        expect_pop(8'h0A, "R4 filtered close");
        drain();
        cfg_filt = 6'd0;

        // R9 R10 R11: overflow with single-tick runs
        cfg_active = 7'd1; cfg_idle = 8'd200;
        for (int i = 0; i < 36; i++) begin
            hold(1, 1); hold(0, 1);
        end
        hold(0, 210);
        check(status == 16'h4013, "R9 full with overflow", status, 16'h4013);
        clear(8'h01);
        check(status == 16'h4012, "R11 clear overflow only", status, 16'h4012);
        expect_pop(8'h81, "R13 oldest entry first");
        check(status[14:8] == 7'd63, "R13 pop removes one", status[14:8], 63);
        drain();
        pop = 1'b1;
        @(negedge clk);
        pop = 1'b0;
        check(status == 16'h0000, "R13 pop on empty", status, 0);
        check(rd_data == 8'h00, "R13 empty data", rd_data, 0);

        repeat (4) @(negedge clk);
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule